// File: doc/BRIEF.md
# Two-Bank Interleaved Read-Ahead Memory Controller

The block connects a 32-bit processor read port to two slow memory banks. Each bank needs two clock cycles per access. Consecutive longwords sit in alternate banks: byte address bit 2 picks the bank, and the bits above it form the row inside the bank. After each delivered longword the controller starts fetching the next sequential longword in the other bank without waiting for a request. The two banks therefore work out of phase, and a sequential stream comes back in a 2-1-1-1 pattern instead of the 2-2-2-2 pattern of one non-interleaved slow memory.

The processor raises `req_i` with a longword-aligned `addr_i` and holds both until `ready_o` is seen. Each bank keeps a one-entry result buffer for its last completed fetch. A request that matches a completed or just-finishing fetch is answered in its first cycle. A miss starts the target bank at once if that bank is free. If the bank is halfway through a speculative fetch, that fetch is allowed to finish first. A busy-bank branch therefore costs three cycles and an idle-bank branch costs two. A started fetch is never cancelled. Speculative data that is never asked for is overwritten later.

Top module: `ilv_rd_ctrl`

## Requirements
- R1: A request whose byte address has bit 2 clear is served by bank 0, and one with bit 2 set is served by bank 1. The row driven on that bank's address port is byte address bits [ADDR_W-1:3].
- R2: A bank start strobe never goes high in the cycle right after that bank's previous start. The bank's data is taken in the cycle after its start.
- R3: While in reset and after reset with no request, `ready_o` and both bank start strobes are low. The first request after reset takes two cycles (ready in its second cycle), and the target bank is started in the request's first cycle.
- R4: `ready_o` is high only while `req_i` is high, for exactly one cycle per delivered longword, and `rdata_o` then holds the longword stored at the requested address.
- R5: In a sequential stream, where each request asks for the previous address plus 4 in the cycle after the previous ready, each longword after the first is ready in its first cycle. A 16-longword burst from idle completes in 17 cycles.
- R6: In the cycle a longword is delivered, the controller starts the next sequential longword in the other bank, as long as that bank is not busy and does not already hold it.
- R7: A non-sequential request that targets a bank halfway through a speculative fetch is ready in its third cycle. No request waits longer than that.
- R8: A non-sequential request that targets an idle bank starts that bank in its first cycle and is ready in its second cycle.
- R9: A request for a longword already held in a bank's result buffer is ready in its first cycle. This includes a repeat of the longword just delivered and a read-ahead that finished during idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, held until ready |
| addr_i | input | ADDR_W | Byte address, longword aligned |
| ready_o | output | 1 | Read data valid this cycle |
| rdata_o | output | DATA_W | Read data |
| bank_start_o | output | 2 | Per-bank access start strobe |
| bank_addr_o | output | 2*(ADDR_W-3) | Per-bank row address, bank 0 in the low slice |
| bank_rdata_i | input | 2*DATA_W | Per-bank read data, valid the cycle after a start |

## Verification
Every cycle, the assertions check the two-cycle occupancy of each bank. They also check that a miss on a free bank starts it at once with the correct row, that ready appears only under a request, and that no request waits past three cycles. Only the directed scenarios can show the exact latencies, because those depend on the history of the two banks. These are the cold start, the 2-1-1-1 stream, the busy-bank and idle-bank branches, the read-ahead strobe in the delivery cycle, and hits on buffered results. Data correctness across the bank mapping is shown by a bank model that returns an address-derived pattern only in the valid cycle.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int NB = 2;
endpackage

// File: rtl/ilv_bank_slot.sv
module ilv_bank_slot #(
  parameter int WW = 30,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [WW-1:0] start_word_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [WW-1:0] req_word_i,
  input  logic [WW-1:0] pf_word_i,
  output logic          busy_o,
  output logic          req_hit_o,
  output logic [DW-1:0] req_data_o,
  output logic          pf_covered_o
);
  logic          ph2_q;
  logic [WW-1:0] fly_word_q;
  logic          buf_vld_q;
  logic [WW-1:0] buf_word_q;
  logic [DW-1:0] buf_data_q;
  logic          fly_hit, buf_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph2_q      <= 1'b0;
      fly_word_q <= '0;
      buf_vld_q  <= 1'b0;
      buf_word_q <= '0;
      buf_data_q <= '0;
    end else begin
      ph2_q <= start_i;
      if (start_i) fly_word_q <= start_word_i;
      if (ph2_q) begin
        buf_vld_q  <= 1'b1;
        buf_word_q <= fly_word_q;
        buf_data_q <= rdata_i;
      end
    end
  end

  // second cycle of an access: bank data on rdata_i now
  assign busy_o       = ph2_q;
  assign fly_hit      = ph2_q && (fly_word_q == req_word_i);
  assign buf_hit      = buf_vld_q && (buf_word_q == req_word_i);
  assign req_hit_o    = fly_hit || buf_hit;
  assign req_data_o   = fly_hit ? rdata_i : buf_data_q;
  assign pf_covered_o = (ph2_q && (fly_word_q == pf_word_i)) ||
                        (buf_vld_q && (buf_word_q == pf_word_i));
endmodule

// File: rtl/ilv_readahead.sv
module ilv_readahead #(
  parameter int WW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          deliver_i,
  input  logic [WW-1:0] deliver_word_i,
  input  logic          drop_i,
  output logic          cand_vld_o,
  output logic [WW-1:0] cand_word_o
);
  logic          pend_q;
  logic [WW-1:0] pend_word_q;
  logic [WW-1:0] next_word;

  assign next_word   = deliver_word_i + WW'(1);
  assign cand_vld_o  = deliver_i || pend_q;
  assign cand_word_o = deliver_i ? next_word : pend_word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_word_q <= '0;
    end else begin
      pend_q <= cand_vld_o && !drop_i;
      if (deliver_i) pend_word_q <= next_word;
    end
  end
endmodule

// File: rtl/ilv_rd_ctrl.sv
module ilv_rd_ctrl
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic                    ready_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [NB-1:0]           bank_start_o,
  output logic [NB*(ADDR_W-3)-1:0] bank_addr_o,
  input  logic [NB*DATA_W-1:0]    bank_rdata_i
);
  localparam int WW = ADDR_W - 2;
  localparam int RW = ADDR_W - 3;

  logic [WW-1:0]     req_word, cand_word;
  logic              req_bank, cand_bank, cand_vld, drop;
  logic [NB-1:0]     busy, hit, cov, dem_go, pf_go;
  logic [DATA_W-1:0] hdata [NB];
  logic [1:0]        unused_lo;

  assign req_word  = addr_i[ADDR_W-1:2];
  assign req_bank  = req_word[0];
  assign unused_lo = addr_i[1:0];
  assign cand_bank = cand_word[0];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [WW-1:0] sword;
    // demand miss beats read-ahead on the same bank
    assign dem_go[g] = req_i && (req_bank == 1'(g)) && !hit[g] && !busy[g];
    assign pf_go[g]  = cand_vld && (cand_bank == 1'(g)) && !busy[g] &&
                       !dem_go[g] && !cov[g];
    assign sword     = dem_go[g] ? req_word : cand_word;
    assign bank_start_o[g]          = dem_go[g] || pf_go[g];
    assign bank_addr_o[g*RW +: RW]  = sword[WW-1:1];

    ilv_bank_slot #(.WW(WW), .DW(DATA_W)) slot_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (bank_start_o[g]),
      .start_word_i (sword),
      .rdata_i      (bank_rdata_i[g*DATA_W +: DATA_W]),
      .req_word_i   (req_word),
      .pf_word_i    (cand_word),
      .busy_o       (busy[g]),
      .req_hit_o    (hit[g]),
      .req_data_o   (hdata[g]),
      .pf_covered_o (cov[g])
    );
  end

  assign ready_o = req_i && hit[req_bank];
  assign rdata_o = hdata[req_bank];
  assign drop    = (|pf_go) || cov[cand_bank];

  ilv_readahead #(.WW(WW)) ra_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .deliver_i      (ready_o),
    .deliver_word_i (req_word),
    .drop_i         (drop),
    .cand_vld_o     (cand_vld),
    .cand_word_o    (cand_word)
  );
endmodule

// File: rtl/ilv_rd_ctrl_chk.sv
module ilv_rd_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic                      ready_o,
  input logic [DATA_W-1:0]         rdata_o,
  input logic [1:0]                bank_start_o,
  input logic [2*(ADDR_W-3)-1:0]   bank_addr_o,
  input logic [2*DATA_W-1:0]       bank_rdata_i
);
  localparam int RW = ADDR_W - 3;
  logic [1:0] wait_q;
  logic [DATA_W-1:0] unused_d;
  logic [DATA_W-1:0] unused_b;
  assign unused_d = rdata_o;
  assign unused_b = bank_rdata_i[DATA_W-1:0] ^ bank_rdata_i[2*DATA_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= '0;
    else if (req_i && !ready_o) wait_q <= (wait_q == 2'd3) ? wait_q : wait_q + 2'd1;
    else wait_q <= '0;
  end

  AST_READY_UNDER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> req_i); // R4
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o) |-> (wait_q < 2'd2)); // R7

  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_BANK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_start_o[g] |=> !bank_start_o[g]); // R2
    AST_MISS_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !ready_o && (addr_i[2] == 1'(g)) && !$past(bank_start_o[g]))
        |-> bank_start_o[g]); // R8
    AST_MISS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !ready_o && (addr_i[2] == 1'(g)) && bank_start_o[g])
        |-> (bank_addr_o[g*RW +: RW] == addr_i[ADDR_W-1:3])); // R1
  end
endmodule

bind ilv_rd_ctrl ilv_rd_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/ilv_rd_ctrl_tb_top.sv
module ilv_rd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int RW = AW - 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ready;
  logic [DW-1:0] rdata;
  logic [1:0]    bstart;
  logic [2*RW-1:0] baddr;
  logic [2*DW-1:0] brdata;

  int checks = 0, failures = 0, viol = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .ready_o(ready), .rdata_o(rdata), .bank_start_o(bstart),
    .bank_addr_o(baddr), .bank_rdata_i(brdata));

  function automatic logic [DW-1:0] pat(input logic [29:0] w);
    return ({2'b00, w} * 32'h9E37_79B1) ^ 32'h3C5A_0000;
  endfunction

  // two-cycle bank models: data only in the cycle after a start
  logic [1:0]    bbusy_q;
  logic [RW-1:0] brow_q [2];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bbusy_q <= '0; brow_q[0] <= '0; brow_q[1] <= '0;
    end else begin
      bbusy_q <= bstart;
      for (int b = 0; b < 2; b++) if (bstart[b]) brow_q[b] <= baddr[b*RW +: RW];
    end
  end
  always_comb begin
    for (int b = 0; b < 2; b++)
      brdata[b*DW +: DW] = bbusy_q[b] ? pat({brow_q[b], 1'(b)}) : (32'hDEAD_0000 | b);
  end
  always @(posedge clk) if (rst_n) for (int b = 0; b < 2; b++)
    if (bstart[b] && bbusy_q[b]) viol++;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  int            lat;
  logic [DW-1:0] got;
  logic [1:0]    first_start, rdy_start;
  logic [2*RW-1:0] first_baddr, rdy_baddr;

  task automatic rd(input logic [AW-1:0] a);
    @(posedge clk); #1;
    req = 1'b1; addr = a; lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin first_start = bstart; first_baddr = baddr; end
      if (ready) begin got = rdata; rdy_start = bstart; rdy_baddr = baddr; break; end
      @(posedge clk); #1;
    end
  endtask

  task automatic gap(input int n);
    @(posedge clk); #1; req = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input int exp_lat, input string rq);
    rd(a);
    check(got == pat(a[AW-1:2]), "R4 data", got, pat(a[AW-1:2]));
    check(lat == exp_lat, rq, lat, exp_lat);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] prev;
    int total, s;
    s = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check(ready == 1'b0 && bstart == 2'b00, "R3 in reset", {ready, bstart}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b0 && bstart == 2'b00, "R3 idle", {ready, bstart}, 0);

    rd_chk(32'h100, 2, "R3 cold latency");
    check(first_start == 2'b01, "R3/R1 cold start bank0", first_start, 1);
    check(first_baddr[RW-1:0] == RW'(32'h100 >> 3), "R1 bank0 row", first_baddr[RW-1:0], 32'h20);
    rd_chk(32'h104, 1, "R5 seq latency");
    check(rdy_start[0] == 1'b1 && rdy_baddr[RW-1:0] == RW'(32'h108 >> 3),
          "R6 read-ahead bank0", {rdy_start, rdy_baddr[RW-1:0]}, {2'b01, 29'h21});
    rd_chk(32'h108, 1, "R5 seq latency");
    check(rdy_start[1] == 1'b1 && rdy_baddr[2*RW-1:RW] == RW'(32'h10C >> 3),
          "R6 read-ahead bank1", rdy_baddr[2*RW-1:RW], 32'h21);
    rd_chk(32'h10C, 1, "R5 seq latency");
    rd_chk(32'h200, 3, "R7 busy-bank branch");
    rd_chk(32'h300, 2, "R8 idle-bank branch");
    check(first_start[0] == 1'b1, "R8 idle bank started at once", first_start, 1);
    rd_chk(32'h304, 1, "R5 seq after branch");
    gap(3);
    rd_chk(32'h308, 1, "R9 buffered read-ahead");
    rd_chk(32'h308, 1, "R9 repeat hit");
    gap(3);

    total = 0;
    for (int i = 0; i < 16; i++) begin
      rd(32'h800 + AW'(i * 4));
      check(got == pat(30'((32'h800 >> 2) + i)), "R4 burst data", got, pat(30'((32'h800 >> 2) + i)));
      total += lat;
    end
    check(total == 17, "R5 burst total cycles", total, 17);

    prev = 32'h1000;
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      if (($urandom % 100) < 65) a = prev + 4;
      else a = AW'(($urandom % 512) << 2);
      if (($urandom % 10) == 0) gap($urandom % 3);
      rd(a);
      check(got == pat(a[AW-1:2]), "R4 random data", got, pat(a[AW-1:2]));
      check(lat >= 1 && lat <= 3, "R7 latency bound", lat, 3);
      prev = a;
    end
    gap(2);
    check(viol == 0, "R2 bank restarted while busy", viol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule